// File: doc/BRIEF.md
# Full-Page Burst Access Controller

This block sits between a processor's single-word memory requests and the command pins of an SDRAM. The SDRAM is run only in full-page, sequential burst mode. The block issues a read or write command, with a column address, only for the first word of a burst. After that it lets the SDRAM's own column counter advance while the processor keeps presenting the next column, one word per cycle.

Each incoming request is compared with the column the burst will reach next. When a stream breaks, the block ends the burst in one of three ways:
- After a write burst, it issues a burst stop with the data mask raised.
- After a read burst, it inserts dummy cycles that throw away the data still in flight, and only then issues the next command.
- If no request follows the dummy cycles, it issues a burst stop.

A row manager elsewhere handles row activation, precharge and refresh. It reports whether a request falls in the open row (`req_hit`), and it flags its own precharge-all cycles (`prea_cyc`).

Top module: `fpb_ctrl`

## Requirements
- R1: Command pins {cs_n, ras_n, cas_n, we_n} carry these codes: read 0101, write 0100, burst stop 0110, no-op 0111, deselect 1111. When idle with nothing to serve, the block drives deselect. After reset the pins show deselect with the data mask low.
- R2: `req_ack` is high only in a cycle where `req_valid`, `req_sdram` and `req_hit` are all high. An accepted request from idle puts a read or write on the pins in the next cycle, with its column on `sd_col` and `sd_a10` low.
- R3: A request in the same direction as the running burst, whose column equals the previous accepted column plus one, is acknowledged in the same cycle. It issues a no-op, so the stream runs at one word per cycle.
- R4: The expected column wraps modulo 2^COL_W. A request to column 0 after the last column of the page counts as sequential.
- R5: In a read burst, any cycle that is not a sequential read starts CL dummy cycles. The first dummy cycle is that same cycle. During the dummy cycles the pins show no-op and `req_ack` stays low. In the cycle after them, a servable request is acknowledged and issued as a new read or write.
- R6: In a write burst, a servable request that is non-sequential or is a read is acknowledged at once and issued as a new command, with no burst stop.
- R7: In a write burst, a cycle with no servable request gives a burst stop with `sd_dqm` high. `req_ack` is low in that cycle, and the block returns to idle. A gap, a non-SDRAM access and a row miss all count as such a cycle.
- R8: If no servable request is present after the dummy cycles that end a read burst, the block issues a burst stop with `sd_dqm` low.
- R9: While `prea_cyc` is high, `sd_dqm` and `sd_a10` are high in that same cycle.
- R10: `sd_dqm` is never raised by read activity: it stays low during read bursts, dummy cycles and the cycles after them, unless `prea_cyc` is high.
- R11: `cas_lat` values 1 to 3 set CL. A value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor presents an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sdram | input | 1 | Access targets the SDRAM region (0 = other region or core-internal cycle) |
| req_hit | input | 1 | Access falls in the currently open row and bank |
| req_col | input | COL_W | Column of the access |
| cas_lat | input | CLW | Read latency in clock cycles, 1 to 3 |
| prea_cyc | input | 1 | The row manager drives precharge-all this cycle |
| req_ack | output | 1 | Access accepted this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Address bit 10: low on read/write, high during precharge-all |
| sd_dqm | output | 1 | Data mask |
| sd_col | output | COL_W | Column address sent with read/write |

## Verification
The bench drives sequential write streams across the page end. These separate a correct modulo wrap from one that restarts the burst. Read streams are broken by a non-sequential read, by a switch to write, by a gap and by a non-SDRAM cycle, at latencies 0, 1, 2 and 3. Each run shows whether the dummy count follows CL and whether the closing command is a new issue or an unmasked burst stop. Write streams are broken by a jump, by a read, by a gap and by a row miss. These tell a direct re-issue apart from a masked burst stop. A precharge-all flag raised while idle checks the mask and A10 in the same cycle.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

  typedef enum logic [2:0] {
    C_DESL, C_NOP, C_RD, C_WR, C_BST
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RD, S_DRAIN, S_RSTOP
  } st_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_e c);
    case (c)
      C_RD:    cmd_pins = 4'b0101;
      C_WR:    cmd_pins = 4'b0100;
      C_BST:   cmd_pins = 4'b0110;
      C_NOP:   cmd_pins = 4'b0111;
      default: cmd_pins = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/fpb_seq_track.sv
// Holds the column the running burst reaches next; wraps at the page end.
module fpb_seq_track #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [COL_W-1:0] col,
  output logic             match
);
  logic [COL_W-1:0] exp_q, exp_d;

  always_comb begin
    exp_d = exp_q;
    if (adv) exp_d = col + COL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_q <= '0;
    else if (adv) exp_q <= exp_d;
  end

  assign match = (col == exp_q);
endmodule

// File: rtl/fpb_drain_cnt.sv
// Counts the dummy cycles that flush a read burst.
module fpb_drain_cnt #(
  parameter int CLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CLW-1:0] cl_eff,
  output logic           last
);
  logic [CLW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start) cnt_d = cl_eff - CLW'(1);
    else if (cnt_q != '0) cnt_d = cnt_q - CLW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CLW'(1));
endmodule

// File: rtl/fpb_cmd_reg.sv
// Registers the command, column and mask that go to the SDRAM pins.
module fpb_cmd_reg
  import fpb_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd_d,
  input  logic             dqm_d,
  input  logic [COL_W-1:0] col_d,
  output logic [3:0]       pins,
  output logic             dqm_q,
  output logic [COL_W-1:0] col_q
);
  cmd_e cmd_q;
  logic col_en;

  assign col_en = (cmd_d == C_RD) || (cmd_d == C_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= C_DESL;
      dqm_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      dqm_q <= dqm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else if (col_en) col_q <= col_d;
  end

  assign pins = cmd_pins(cmd_q);

  // R10: the mask register never rises on the cycle after a read command
  p_rd_no_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD) |-> !dqm_q);
endmodule

// File: rtl/fpb_ctrl.sv
module fpb_ctrl
  import fpb_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int CLW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_sdram,
  input  logic             req_hit,
  input  logic [COL_W-1:0] req_col,
  input  logic [CLW-1:0]   cas_lat,
  input  logic             prea_cyc,
  output logic             req_ack,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_a10,
  output logic             sd_dqm,
  output logic [COL_W-1:0] sd_col
);
  st_e            st_q, st_d;
  cmd_e           cmd_d;
  logic           dqm_d, adv, start, last, match, serve, dqm_q;
  logic [CLW-1:0] cl_eff;
  logic [3:0]     pins;

  assign cl_eff = (cas_lat == '0) ? CLW'(1) : cas_lat;
  assign serve  = req_valid && req_sdram && req_hit;

  fpb_seq_track #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .col(req_col), .match(match));

  fpb_drain_cnt #(.CLW(CLW)) u_drain (
    .clk(clk), .rst_n(rst_n), .start(start), .cl_eff(cl_eff), .last(last));

  fpb_cmd_reg #(.COL_W(COL_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_d(cmd_d), .dqm_d(dqm_d), .col_d(req_col),
    .pins(pins), .dqm_q(dqm_q), .col_q(sd_col));

  // next-state process
  always_comb begin
    st_d    = st_q;
    cmd_d   = C_NOP;
    dqm_d   = 1'b0;
    req_ack = 1'b0;
    adv     = 1'b0;
    start   = 1'b0;
    case (st_q)
      S_IDLE, S_RSTOP: begin
        if (serve) begin
          req_ack = 1'b1;
          adv     = 1'b1;
          cmd_d   = req_write ? C_WR : C_RD;
          st_d    = req_write ? S_WR : S_RD;
        end else if (st_q == S_RSTOP) begin
          cmd_d = C_BST;
          st_d  = S_IDLE;
        end else begin
          cmd_d = C_DESL;
        end
      end
      S_WR: begin
        if (serve) begin
          req_ack = 1'b1;
          adv     = 1'b1;
          if (!(req_write && match)) begin
            cmd_d = req_write ? C_WR : C_RD;
            st_d  = req_write ? S_WR : S_RD;
          end
        end else begin
          cmd_d = C_BST;
          dqm_d = 1'b1;
          st_d  = S_IDLE;
        end
      end
      S_RD: begin
        if (serve && !req_write && match) begin
          req_ack = 1'b1;
          adv     = 1'b1;
        end else begin
          start = 1'b1;
          st_d  = (cl_eff == CLW'(1)) ? S_RSTOP : S_DRAIN;
        end
      end
      S_DRAIN: begin
        if (last) st_d = S_RSTOP;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
  assign sd_dqm = dqm_q || prea_cyc;
  assign sd_a10 = prea_cyc;

  // R2: acceptance only for a servable request
  p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (req_valid && req_sdram && req_hit));

  // R3: a sequential continuation issues no new command
  p_seq_no_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_RD || st_q == S_WR) && req_ack && match &&
     (req_write == (st_q == S_WR))) |=> (pins == 4'b0111));

  // R5: no acceptance while the read pipeline is being flushed
  p_drain_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DRAIN) |-> !req_ack);

  // R7: an unserved cycle in a write burst gives a masked burst stop
  p_wr_stop_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WR && !serve) |=> (pins == 4'b0110 && sd_dqm));
endmodule

// File: tb/fpb_ctrl_bench.sv
module fpb_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int COL_W = 8;
  localparam int CLW   = 2;
  localparam logic [3:0] P_DESL = 4'b1111, P_NOP = 4'b0111, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_BST = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_sdram = 0, req_hit = 0, prea_cyc = 0;
  logic [COL_W-1:0] req_col = '0;
  logic [CLW-1:0]   cas_lat = 2'd2;
  logic req_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_dqm;
  logic [COL_W-1:0] sd_col;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  fpb_ctrl #(.COL_W(COL_W), .CLW(CLW)) u_fpb_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sdram(req_sdram), .req_hit(req_hit), .req_col(req_col),
    .cas_lat(cas_lat), .prea_cyc(prea_cyc), .req_ack(req_ack),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_a10(sd_a10), .sd_dqm(sd_dqm), .sd_col(sd_col));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock cycle: drive at the falling edge, check ack, then check the pins
  // that the rising edge registers.
  task automatic step(input bit v, w, s, h, input int col, input bit e_ack,
                      input logic [3:0] e_pins, input bit e_dqm,
                      input int e_col, input string req);
    @(negedge clk);
    req_valid = v; req_write = w; req_sdram = s; req_hit = h;
    req_col = COL_W'(col);
    #1;
    chk({req, " ack"}, 16'(req_ack), 16'(e_ack));
    @(posedge clk);
    #1;
    chk({req, " pins"}, 16'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 16'(e_pins));
    chk({req, " dqm"}, 16'(sd_dqm), 16'(e_dqm));
    if (e_col >= 0) chk({req, " col"}, 16'(sd_col), 16'(e_col));
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset pins", 16'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 16'(P_DESL));
    chk("R1 reset dqm", 16'(sd_dqm), 16'(0));
    step(0,0,0,0,0, 0, P_DESL, 0, -1, "R1 idle deselect");
  endtask

  task automatic t_write_wrap;
    step(1,1,1,1,254, 1, P_WR, 0, 254, "R2 first write");
    step(1,1,1,1,255, 1, P_NOP, 0, -1, "R3 sequential write");
    step(1,1,1,1,0,   1, P_NOP, 0, -1, "R4 page wrap");
    step(1,1,1,1,1,   1, P_NOP, 0, -1, "R4 after wrap");
    step(0,0,0,0,0,   0, P_BST, 1, -1, "R7 gap stops write");
    step(0,0,0,0,0,   0, P_DESL, 0, -1, "R1 back to idle");
  endtask

  task automatic t_read_break_cl2;
    cas_lat = 2'd2;
    step(1,0,1,1,10, 1, P_RD, 0, 10, "R2 first read");
    step(1,0,1,1,11, 1, P_NOP, 0, -1, "R3 sequential read");
    step(1,0,1,1,20, 0, P_NOP, 0, -1, "R5 dummy 1");
    step(1,0,1,1,20, 0, P_NOP, 0, -1, "R5 dummy 2");
    step(1,0,1,1,20, 1, P_RD, 0, 20, "R5 reissue read");
    step(0,0,0,0,0,  0, P_NOP, 0, -1, "R10 dummy mask low");
    step(0,0,0,0,0,  0, P_NOP, 0, -1, "R10 dummy 2 mask low");
    step(0,0,0,0,0,  0, P_BST, 0, -1, "R8 read stop unmasked");
    step(0,0,0,0,0,  0, P_DESL, 0, -1, "R1 idle after read");
  endtask

  task automatic t_read_to_write_cl3;
    cas_lat = 2'd3;
    step(1,0,1,1,5, 1, P_RD, 0, 5, "R11 read cl3");
    step(1,1,1,1,6, 0, P_NOP, 0, -1, "R5 rw dummy 1");
    step(1,1,1,1,6, 0, P_NOP, 0, -1, "R5 rw dummy 2");
    step(1,1,1,1,6, 0, P_NOP, 0, -1, "R5 rw dummy 3");
    step(1,1,1,1,6, 1, P_WR, 0, 6, "R5 write after read");
    step(0,0,0,0,0, 0, P_BST, 1, -1, "R7 stop");
  endtask

  task automatic t_low_latency;
    cas_lat = 2'd1;
    step(1,0,1,1,7, 1, P_RD, 0, 7, "R11 read cl1");
    step(1,0,1,1,9, 0, P_NOP, 0, -1, "R5 single dummy");
    step(1,0,1,1,9, 1, P_RD, 0, 9, "R5 reissue cl1");
    step(0,0,0,0,0, 0, P_NOP, 0, -1, "R5 gap dummy cl1");
    step(0,0,0,0,0, 0, P_BST, 0, -1, "R8 stop cl1");
    cas_lat = 2'd0;
    step(1,0,1,1,3, 1, P_RD, 0, 3, "R11 read cl0");
    step(0,0,0,0,0, 0, P_NOP, 0, -1, "R11 cl0 one dummy");
    step(0,0,0,0,0, 0, P_BST, 0, -1, "R11 cl0 stop");
    step(0,0,0,0,0, 0, P_DESL, 0, -1, "R1 idle");
  endtask

  task automatic t_write_redirect;
    cas_lat = 2'd2;
    step(1,1,1,1,30, 1, P_WR, 0, 30, "R2 write");
    step(1,1,1,1,40, 1, P_WR, 0, 40, "R6 nonseq write reissue");
    step(1,0,1,1,41, 1, P_RD, 0, 41, "R6 write to read");
    step(1,0,0,1,42, 0, P_NOP, 0, -1, "R5 non-sdram dummy 1");
    step(1,0,0,1,42, 0, P_NOP, 0, -1, "R5 non-sdram dummy 2");
    step(1,0,0,1,42, 0, P_BST, 0, -1, "R8 non-sdram stop");
  endtask

  task automatic t_miss;
    step(1,1,1,0,50, 0, P_DESL, 0, -1, "R2 miss not accepted");
    step(1,1,1,1,50, 1, P_WR, 0, 50, "R2 write after hit");
    step(1,1,1,0,51, 0, P_BST, 1, -1, "R7 miss stops write");
    step(1,1,0,1,52, 0, P_DESL, 0, -1, "R2 non-sdram ignored");
  endtask

  task automatic t_prea;
    @(negedge clk);
    req_valid = 0; prea_cyc = 1;
    #1;
    chk("R9 prea dqm", 16'(sd_dqm), 16'(1));
    chk("R9 prea a10", 16'(sd_a10), 16'(1));
    @(negedge clk);
    prea_cyc = 0;
    #1;
    chk("R9 prea released dqm", 16'(sd_dqm), 16'(0));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    #(CLK_P*2 + 2);
    rst_n = 1'b1;
    t_reset();
    t_write_wrap();
    t_read_break_cl2();
    t_read_to_write_cl3();
    t_low_latency();
    t_write_redirect();
    t_miss();
    t_prea();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule